// File: doc/BRIEF.md
# ATM Transmit Cell Generator

This block sits between the transmit cell FIFO and the framing stage. It emits a gap-free stream of 53-octet ATM cells, one octet per clock. At every cell boundary it picks the source of the next cell:

- a user-defined OAM cell, if software has asked for one;
- otherwise a user cell from the FIFO, if the FIFO holds a complete cell;
- otherwise an idle cell, built from a programmable header and a programmable payload byte.

The OAM cell comes from a 54-byte buffer that software writes through a simple byte port. Each send command produces exactly one OAM cell. The block writes a CRC-10 into the last ten bits of every OAM payload.

The fifth octet can carry a generated HEC. The 48 payload octets can be scrambled. Each of these is switched by its own enable input. The idle configuration inputs are normally tied to header 0x00000001 and payload byte 0x6A.

The control path is a four-state machine:

- ST_START is the single cycle after reset. It chooses the first cell kind and moves to ST_HDR.
- ST_HDR covers octets 1 to 4. It moves to ST_HEC after octet 4.
- ST_HEC covers octet 5 and always moves to ST_PAY.
- ST_PAY covers octets 6 to 53. After octet 53 it picks the next cell kind and returns to ST_HDR.

Top module: `atm_tx_cell_gen`

## Requirements
- R1: The first octet of the first cell appears, with out_sop and out_valid high, on the second rising edge after rst_n is released. After that, out_valid stays high every cycle, and out_sop marks octet 1 exactly every 53 cycles.
- R2: The kind of the next cell is chosen at the cell boundary in the order OAM, then user, then idle. A pending OAM command wins over a complete cell waiting in the FIFO. out_kind encodes idle as 0, user as 1 and OAM as 2, and is constant within a cell.
- R3: fifo_rd is high for exactly the 53 cycles in which a user cell is processed, and fifo_data is taken in the same cycle (first-word fall-through). A user cell is started only if fifo_cell_avail was high at the boundary.
- R4: A pulse on oam_send sets a pending request that is served at the next cell boundary and then cleared, giving one OAM cell per command. oam_done rises as the last octet of that OAM cell is output, and it is cleared on the cycle after any oam_send.
- R5: An idle cell carries idle_hdr bits 31:24, 23:16, 15:8 and 7:0 as octets 1 to 4, then 0x00 as octet 5 before HEC handling, then idle_pay in all 48 payload octets.
- R6: An OAM cell carries buffer bytes 0 to 52 in order. The low 2 bits of octet 52 and all of octet 53 are replaced by the CRC-10 with generator x^10+x^9+x^5+x^4+x+1. This CRC is the remainder of the 48 unscrambled payload octets, with those 10 bits set to zero, divided by the generator, MSB first. Octet 52 bits 1:0 hold CRC bits 9:8, and octet 53 holds CRC bits 7:0.
- R7: With hec_en high, octet 5 of every cell is the CRC-8 remainder (generator x^8+x^2+x+1, MSB first) of octets 1 to 4 followed by eight zero bits, XORed with 0x55. The default idle header therefore gives 0x52. With hec_en low, octet 5 passes the source byte: the FIFO byte for a user cell, buffer byte 4 for an OAM cell, and 0x00 for an idle cell.
- R8: With scr_en high, each payload bit d (MSB first) is sent as s = d XOR the bit sent 43 scrambled bits earlier. The history is zero after reset and advances only over scrambled payload bits. Header and octet 5 are never scrambled. With scr_en low, the payload passes unchanged and the history is held.
- R9: While rst_n is low, out_valid, out_sop, fifo_rd and oam_done are low, and any pending OAM request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_cell_avail | input | 1 | FIFO holds at least one complete cell |
| fifo_data | input | 8 | Octet at the FIFO head |
| fifo_rd | output | 1 | Consume the FIFO head octet this cycle |
| idle_hdr | input | 32 | Idle cell header, octet 1 in bits 31:24 |
| idle_pay | input | 8 | Idle cell payload byte |
| hec_en | input | 1 | Insert generated HEC into octet 5 |
| scr_en | input | 1 | Scramble payload octets |
| oam_wr_en | input | 1 | Write strobe for the OAM buffer |
| oam_wr_addr | input | 6 | OAM buffer byte index |
| oam_wr_data | input | 8 | OAM buffer write byte |
| oam_send | input | 1 | One-cycle OAM send command |
| oam_done | output | 1 | Last requested OAM cell has been sent |
| out_valid | output | 1 | out_data carries a cell octet |
| out_sop | output | 1 | out_data is octet 1 of a cell |
| out_data | output | 8 | Cell octet to the framing stage |
| out_kind | output | 2 | Kind of the cell on out_data |

## Verification
The assertions check the following on every cycle:
- the 53-cycle spacing of out_sop and the absence of gaps;
- that out_kind holds steady inside a cell;
- that a FIFO read burst starts only after a complete cell was reported;
- that oam_done rises only on an OAM cell and clears after a command.

Only the bench scenarios can show the following:
- the content of each cell: the HEC value, the CRC-10 placement over unscrambled data, and the scrambler history carried across cells and held while scrambling is off;
- the OAM-before-user priority when both are waiting.

// File: rtl/atm_tx_pkg.sv
package atm_tx_pkg;

    localparam int CELL_OCTETS = 53;
    localparam int HDR_OCTETS  = 4;
    localparam int PAY_OCTETS  = 48;
    localparam logic [7:0] HEC_COSET = 8'h55;
    localparam logic [7:0] HEC_POLY  = 8'h07;
    localparam logic [9:0] CRC10_POLY = 10'h233;

    typedef enum logic [1:0] {
        CK_IDLE = 2'd0,
        CK_USER = 2'd1,
        CK_OAM  = 2'd2
    } cell_kind_e;

    typedef enum logic [1:0] {
        ST_START,
        ST_HDR,
        ST_HEC,
        ST_PAY
    } tx_state_e;

    // CRC-8 shift of one octet, MSB first
    function automatic logic [7:0] hec_step(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[7] ^ d[i]) r = {r[6:0], 1'b0} ^ HEC_POLY;
            else             r = {r[6:0], 1'b0};
        end
        return r;
    endfunction

    // CRC-10 shift of the top nbits of an octet, MSB first
    function automatic logic [9:0] crc10_step(input logic [9:0] c, input logic [7:0] d,
                                              input int nbits);
        logic [9:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (i < nbits) begin
                if (r[9] ^ d[7-i]) r = {r[8:0], 1'b0} ^ CRC10_POLY;
                else               r = {r[8:0], 1'b0};
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/atm_tx_oam_buf.sv
module atm_tx_oam_buf #(
    parameter int DEPTH = 54,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && (int'(wr_addr) < DEPTH)) mem[wr_addr] <= wr_data;
    end

    assign rd_data = (int'(rd_addr) < DEPTH) ? mem[rd_addr] : 8'h00;
endmodule

// File: rtl/atm_tx_scrambler.sv
module atm_tx_scrambler #(
    parameter int LEN = 43
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv,
    input  logic [7:0] din,
    output logic [7:0] dout
);
    logic [LEN-1:0] hist_q, hist_d;

    always_comb begin
        hist_d = hist_q;
        for (int i = 7; i >= 0; i--) begin
            dout[i] = din[i] ^ hist_d[LEN-1];
            hist_d  = {hist_d[LEN-2:0], dout[i]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   hist_q <= '0;
        else if (adv) hist_q <= hist_d;
    end
endmodule

// File: rtl/atm_tx_cell_gen.sv
module atm_tx_cell_gen
    import atm_tx_pkg::*;
#(
    parameter int OAM_DEPTH = 54,
    parameter int SCR_LEN   = 43,
    localparam int OAM_AW   = $clog2(OAM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_cell_avail,
    input  logic [7:0]        fifo_data,
    output logic              fifo_rd,
    input  logic [31:0]       idle_hdr,
    input  logic [7:0]        idle_pay,
    input  logic              hec_en,
    input  logic              scr_en,
    input  logic              oam_wr_en,
    input  logic [OAM_AW-1:0] oam_wr_addr,
    input  logic [7:0]        oam_wr_data,
    input  logic              oam_send,
    output logic              oam_done,
    output logic              out_valid,
    output logic              out_sop,
    output logic [7:0]        out_data,
    output logic [1:0]        out_kind
);
    localparam int IW = $clog2(CELL_OCTETS);
    localparam logic [IW-1:0] HDR_LAST = IW'(HDR_OCTETS - 1);
    localparam logic [IW-1:0] PAY_FIRST = IW'(HDR_OCTETS + 1);
    localparam logic [IW-1:0] CELL_LAST = IW'(CELL_OCTETS - 1);
    localparam logic [IW-1:0] CRC_HI = IW'(CELL_OCTETS - 2);

    tx_state_e  st_q, st_d;
    cell_kind_e kind_q, next_kind;
    logic [IW-1:0] idx_q;
    logic       oam_pend_q, oam_done_q;
    logic [7:0] hec_acc_q, hec_cur;
    logic [9:0] crc_acc_q, crc_next;
    logic [7:0] buf_byte, raw, pay, scr_byte, byte_out;
    logic       cell_end, scr_adv;

    atm_tx_oam_buf #(.DEPTH(OAM_DEPTH)) u_buf (
        .clk(clk), .wr_en(oam_wr_en), .wr_addr(oam_wr_addr), .wr_data(oam_wr_data),
        .rd_addr(OAM_AW'(idx_q)), .rd_data(buf_byte)
    );

    atm_tx_scrambler #(.LEN(SCR_LEN)) u_scr (
        .clk(clk), .rst_n(rst_n), .adv(scr_adv), .din(pay), .dout(scr_byte)
    );

    assign cell_end  = (st_q == ST_START) || (st_q == ST_PAY && idx_q == CELL_LAST);
    assign next_kind = oam_pend_q ? CK_OAM : (fifo_cell_avail ? CK_USER : CK_IDLE);
    assign fifo_rd   = (st_q != ST_START) && (kind_q == CK_USER);
    assign scr_adv   = (st_q == ST_PAY) && scr_en;
    assign oam_done  = oam_done_q;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_START: st_d = ST_HDR;
            ST_HDR:   if (idx_q == HDR_LAST) st_d = ST_HEC;
            ST_HEC:   st_d = ST_PAY;
            ST_PAY:   if (idx_q == CELL_LAST) st_d = ST_HDR;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_START;
            idx_q  <= '0;
            kind_q <= CK_IDLE;
        end else begin
            st_q  <= st_d;
            idx_q <= cell_end ? '0 : idx_q + 1'b1;
            if (cell_end) kind_q <= next_kind;
        end
    end

    // octet datapath and outputs
    always_comb begin
        unique case (kind_q)
            CK_USER: raw = fifo_data;
            CK_OAM:  raw = buf_byte;
            default: begin
                if (idx_q > HDR_LAST) raw = (idx_q == PAY_FIRST - 1'b1) ? 8'h00 : idle_pay;
                else begin
                    unique case (idx_q[1:0])
                        2'd0: raw = idle_hdr[31:24];
                        2'd1: raw = idle_hdr[23:16];
                        2'd2: raw = idle_hdr[15:8];
                        default: raw = idle_hdr[7:0];
                    endcase
                end
            end
        endcase
        hec_cur = hec_step((idx_q == '0) ? 8'h00 : hec_acc_q, raw);
        pay = raw;
        crc_next = crc10_step((idx_q == PAY_FIRST) ? 10'h000 : crc_acc_q, raw, 8);
        if (kind_q == CK_OAM && idx_q == CRC_HI) begin
            crc_next = crc10_step(crc_acc_q, raw, 6);
            pay = {raw[7:2], crc_next[9:8]};
        end else if (kind_q == CK_OAM && idx_q == CELL_LAST) begin
            crc_next = crc_acc_q;
            pay = crc_acc_q[7:0];
        end
        unique case (st_q)
            ST_HEC:  byte_out = hec_en ? (hec_acc_q ^ HEC_COSET) : raw;
            ST_PAY:  byte_out = scr_en ? scr_byte : pay;
            default: byte_out = raw;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oam_pend_q <= 1'b0;
            oam_done_q <= 1'b0;
            hec_acc_q  <= '0;
            crc_acc_q  <= '0;
            out_valid  <= 1'b0;
            out_sop    <= 1'b0;
            out_data   <= '0;
            out_kind   <= CK_IDLE;
        end else begin
            if (oam_send) oam_pend_q <= 1'b1;
            else if (cell_end && oam_pend_q) oam_pend_q <= 1'b0;
            if (oam_send) oam_done_q <= 1'b0;
            else if (st_q == ST_PAY && idx_q == CELL_LAST && kind_q == CK_OAM) oam_done_q <= 1'b1;
            if (st_q == ST_HDR) hec_acc_q <= hec_cur;
            if (st_q == ST_PAY) crc_acc_q <= crc_next;
            out_valid <= (st_q != ST_START);
            out_sop   <= (st_q == ST_HDR) && (idx_q == '0);
            out_data  <= (st_q == ST_START) ? 8'h00 : byte_out;
            out_kind  <= kind_q;
        end
    end
endmodule

// File: rtl/atm_tx_cell_gen_chk.sv
module atm_tx_cell_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fifo_cell_avail,
    input logic       fifo_rd,
    input logic       oam_send,
    input logic       oam_done,
    input logic       out_valid,
    input logic       out_sop,
    input logic [1:0] out_kind
);
    logic [5:0] gap_q;
    logic       seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            gap_q  <= out_sop ? 6'd0 : gap_q + 6'd1;
            if (out_sop) seen_q <= 1'b1;
        end
    end

    // R1: octet 1 recurs every 53 cycles
    a_r1_sop_period: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sop && seen_q) |-> (gap_q == 6'd52));
    // R1: no gap once the stream runs
    a_r1_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> out_valid);
    // R2: cell kind constant inside a cell
    a_r2_kind_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_sop && $past(out_valid)) |-> $stable(out_kind));
    // R3: a read burst needs a complete cell
    a_r3_rd_needs_avail: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fifo_rd) |-> $past(fifo_cell_avail));
    // R4: done rises only with an OAM cell
    a_r4_done_on_oam: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oam_done) |-> (out_kind == 2'd2));
    // R4: a command clears done
    a_r4_send_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
        oam_send |=> !oam_done);
endmodule

bind atm_tx_cell_gen atm_tx_cell_gen_chk chk_i (
    .clk(clk), .rst_n(rst_n), .fifo_cell_avail(fifo_cell_avail), .fifo_rd(fifo_rd),
    .oam_send(oam_send), .oam_done(oam_done), .out_valid(out_valid),
    .out_sop(out_sop), .out_kind(out_kind)
);

// File: tb/atm_tx_cell_gen_tb_top.sv
`timescale 1ns/1ps
module atm_tx_cell_gen_tb_top;
    localparam int FSZ = 53 * 8;
    // {oam, push, hec, scr, kind[1:0], hdr_alt, 0, pay[7:0]}; kind 0 idle 1 user 2 oam
    localparam logic [15:0] VEC [10] = '{
        16'h206A, 16'h646A, 16'h446A, 16'hA86A, 16'hF86A,
        16'h346A, 16'h106A, 16'h22A5, 16'h746A, 16'h886A
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic fifo_cell_avail, fifo_rd, hec_en, scr_en, oam_wr_en, oam_send, oam_done;
    logic out_valid, out_sop;
    logic [7:0] fifo_data, idle_pay, oam_wr_data, out_data;
    logic [5:0] oam_wr_addr;
    logic [31:0] idle_hdr;
    logic [1:0] out_kind;

    logic [7:0] fmem [FSZ];
    logic [7:0] oam_img [54];
    int wr_ptr = 0, rd_ptr = 0, prev_rd = 0, pushes = 0, used = 0;
    int total = 0, bad = 0;
    logic [42:0] bst = '0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    assign fifo_cell_avail = (wr_ptr - rd_ptr) >= 53;
    assign fifo_data = (rd_ptr < FSZ) ? fmem[rd_ptr] : 8'h00;
    always @(posedge clk) if (rst_n && fifo_rd) rd_ptr <= rd_ptr + 1;

    atm_tx_cell_gen dut_i (
        .clk(clk), .rst_n(rst_n), .fifo_cell_avail(fifo_cell_avail), .fifo_data(fifo_data),
        .fifo_rd(fifo_rd), .idle_hdr(idle_hdr), .idle_pay(idle_pay), .hec_en(hec_en),
        .scr_en(scr_en), .oam_wr_en(oam_wr_en), .oam_wr_addr(oam_wr_addr),
        .oam_wr_data(oam_wr_data), .oam_send(oam_send), .oam_done(oam_done),
        .out_valid(out_valid), .out_sop(out_sop), .out_data(out_data), .out_kind(out_kind)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] user_byte(input int n, input int i);
        logic [31:0] h;
        h = {8'h0C, 8'h12, 8'h34, 8'(8'h50 + n)};
        if (i < 4) return h[31 - 8*i -: 8];
        if (i == 4) return 8'hEE;
        return 8'((i * 7 + n * 13) & 255);
    endfunction

    function automatic logic [7:0] hec_ref(input logic [31:0] h);
        logic [8:0] r;
        logic [39:0] m;
        r = '0;
        m = {h, 8'h00};
        for (int i = 39; i >= 0; i--) begin
            r = {r[7:0], m[i]};
            if (r[8]) r = r ^ 9'h107;
        end
        return r[7:0] ^ 8'h55;
    endfunction

    function automatic logic [9:0] crc10_ref(input logic [7:0] p [48]);
        logic [10:0] r;
        r = '0;
        for (int k = 0; k < 48; k++)
            for (int b = 7; b >= 0; b--) begin
                r = {r[9:0], p[k][b]};
                if (r[10]) r = r ^ 11'h633;
            end
        return r[9:0];
    endfunction

    task automatic push_user();
        for (int i = 0; i < 53; i++) fmem[wr_ptr + i] = user_byte(pushes, i);
        wr_ptr += 53;
        pushes++;
    endtask

    task automatic apply_cfg(input logic [15:0] v);
        hec_en = v[13];
        scr_en = v[12];
        idle_pay = v[7:0];
        idle_hdr = v[9] ? 32'h00ABC00F : 32'h00000001;
    endtask

    task automatic run_cell(input bit wait_first, input bit has_nx, input logic [15:0] nv,
                            input logic [1:0] ek, input int cno);
        logic [7:0] got [53];
        logic [7:0] ex [53];
        logic [7:0] p [48];
        logic [1:0] gk;
        logic c_hec, c_scr;
        logic [31:0] c_hdr;
        logic [7:0] c_pay;
        logic [9:0] crc;
        bit sent;
        int bad_at;
        c_hec = hec_en; c_scr = scr_en; c_hdr = idle_hdr; c_pay = idle_pay;
        sent = 0;
        gk = 2'd3;
        for (int pos = 0; pos < 53; pos++) begin
            if (pos > 0 || wait_first) @(negedge clk);
            got[pos] = out_data;
            if (pos == 0) begin
                gk = out_kind;
                chk(out_sop === 1'b1, "R1", $sformatf("sop cell %0d", cno), out_sop, 1);
            end
            if (pos == 41 && sent) begin
                chk(oam_done === 1'b0, "R4", "done cleared by send", oam_done, 0);
            end
            if (pos == 41) oam_send = 1'b0;
            if (has_nx && pos == 40) begin
                if (nv[14]) push_user();
                if (nv[15]) begin oam_send = 1'b1; sent = 1; end
            end
            if (pos == 52) begin
                if (ek == 2'd2) chk(oam_done === 1'b1, "R4", "done after OAM cell", oam_done, 1);
                chk((rd_ptr - prev_rd) == ((ek == 2'd1) ? 53 : 0), "R3",
                    $sformatf("fifo reads cell %0d", cno), rd_ptr - prev_rd, (ek == 2'd1) ? 53 : 0);
                prev_rd = rd_ptr;
                if (has_nx) apply_cfg(nv);
            end
        end
        chk(gk == ek, "R2", $sformatf("kind cell %0d", cno), gk, ek);
        // expected octets
        for (int i = 0; i < 53; i++) begin
            if (ek == 2'd1) ex[i] = user_byte(used, i);
            else if (ek == 2'd2) ex[i] = oam_img[i];
            else ex[i] = (i < 4) ? c_hdr[31 - 8*i -: 8] : ((i == 4) ? 8'h00 : c_pay);
        end
        if (ek == 2'd1) used++;
        if (ek == 2'd2) begin
            for (int k = 0; k < 48; k++) p[k] = ex[5 + k];
            p[46][1:0] = 2'b00;
            p[47] = 8'h00;
            crc = crc10_ref(p);
            ex[51] = {ex[51][7:2], crc[9:8]};
            ex[52] = crc[7:0];
        end
        if (c_hec) ex[4] = hec_ref({ex[0], ex[1], ex[2], ex[3]});
        if (c_scr) begin
            for (int k = 5; k < 53; k++)
                for (int b = 7; b >= 0; b--) begin
                    ex[k][b] = ex[k][b] ^ bst[42];
                    bst = {bst[41:0], ex[k][b]};
                end
        end
        bad_at = -1;
        for (int i = 52; i >= 0; i--) if (got[i] !== ex[i]) bad_at = i;
        chk(bad_at < 0, (ek == 2'd2) ? "R6 R7 R8" : ((ek == 2'd1) ? "R7 R8" : "R5 R7 R8"),
            $sformatf("cell %0d octet %0d", cno, bad_at < 0 ? 0 : bad_at),
            (bad_at < 0) ? 0 : got[bad_at], (bad_at < 0) ? 0 : ex[bad_at]);
    endtask

    initial begin
        oam_send = 0; oam_wr_en = 0; oam_wr_addr = '0; oam_wr_data = '0;
        apply_cfg(16'h206A);
        for (int i = 0; i < 54; i++)
            oam_img[i] = (i < 3) ? 8'h00 : (i == 3) ? 8'h1A : (i == 4) ? 8'h3C :
                         (i >= 51) ? 8'hFF : 8'(8'h10 + i);
        for (int i = 0; i < 54; i++) begin
            @(negedge clk);
            oam_wr_en = 1; oam_wr_addr = 6'(i); oam_wr_data = oam_img[i];
        end
        @(negedge clk);
        oam_wr_en = 0;
        // R9: reset state
        chk(out_valid === 0 && out_sop === 0, "R9", "outputs idle in reset", out_valid, 0);
        chk(fifo_rd === 0 && oam_done === 0, "R9", "no read or done in reset", fifo_rd, 0);
        rst_n = 1;
        @(negedge clk);
        chk(out_valid === 0, "R1", "no octet after first edge", out_valid, 0);
        @(negedge clk);
        chk(out_valid === 1, "R1", "valid on second edge", out_valid, 1);
        // table walk: cell c is steered by VEC[c-1]
        for (int c = 0; c <= 10; c++)
            run_cell(c != 0, c < 10, (c < 10) ? VEC[c] : 16'h0,
                     (c == 0) ? 2'd0 : VEC[c-1][11:10], c);
        // R9: reset mid-stream drops a pending command and history
        @(negedge clk);
        oam_send = 1;
        @(negedge clk);
        oam_send = 0; rst_n = 0;
        apply_cfg(16'h306A);
        @(negedge clk);
        @(negedge clk);
        chk(out_valid === 0 && fifo_rd === 0, "R9", "mid-stream reset", out_valid, 0);
        chk(oam_done === 0, "R9", "done cleared by reset", oam_done, 0);
        bst = '0;
        rst_n = 1;
        @(negedge clk);
        @(negedge clk);
        run_cell(0, 0, 16'h0, 2'd0, 11);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule